// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer accepts one memory request on behalf of a group of 32 lanes. Each lane supplies a byte address, and an active mask marks which lanes take part. The block splits the request into the fewest aligned segment transactions that cover every active lane's address, and emits them one at a time. Each transaction gives the segment base, the segment size in bytes and a mask of the lanes it serves. When every active address falls in one segment, a single transaction results. Addresses that are far apart cost one transaction per segment they touch, and a whole segment is requested even when only one byte of it is used.

The segment size is picked per request: 32, 64 or 128 bytes. Requests arrive on a valid/ready port and transactions leave on a valid/ready port. The request port is ready only while no request is in progress. A transaction stays on the output, unchanged, until the consumer accepts it. A one-cycle completion pulse follows the last transaction, or follows acceptance when no lane is active. Read data, memory timing and data reassembly are outside this block.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, txn_valid is 0 and done is 0.
- R2: The size code req_seg selects the segment size: 0 gives 32 bytes, 1 gives 64 bytes, 2 and 3 give 128 bytes. txn_bytes reports that size, and txn_base is the lane address with its low log2(size) bits cleared.
- R3: A request produces exactly one transaction for each distinct aligned segment touched by an active lane. Lanes in one segment share one transaction.
- R4: A lane whose req_mask bit is 0 never appears in txn_lanes and never causes a transaction.
- R5: Each transaction covers the segment of the lowest-numbered active lane not yet served. Bit i of txn_lanes is set exactly for the unserved active lanes i whose address lies in that segment.
- R6: While txn_valid is 1 and txn_ready is 0, txn_base, txn_bytes, txn_lanes and txn_last hold. req_ready is 0 from the cycle after a request with active lanes is accepted until its last transaction is accepted.
- R7: txn_last is 1 only on the final transaction of a request. done is 1 for exactly the one cycle after that transaction is accepted.
- R8: A request with req_mask all zero produces no transaction, and done is 1 in the cycle after its acceptance.
- R9: The first transaction is valid in the cycle after the request is accepted. While txn_ready stays 1, a new transaction is presented every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| req_mask | input | 32 | Active lanes, bit i for lane i |
| req_seg | input | 2 | Segment size code (see R2) |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Consumer accepts the transaction |
| txn_base | output | 32 | Aligned segment base address |
| txn_bytes | output | 8 | Segment size in bytes |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_last | output | 1 | Final transaction of the request |
| done | output | 1 | One-cycle pulse when a request is finished |

## Verification
A corrupted pending-lane register shows up at the ports at once. The next transaction then points at the wrong segment, carries a wrong lane mask, or the transaction count for the request comes out wrong. A lost clear of served lanes repeats a segment, and a lost busy flag lets a new request in or drops done. Each of these appears within one cycle of the faulty update. A per-cycle reference model compares every transaction field, req_ready and done, and the bench checks per-request transaction counts for strides, scatter, partial masks and stalled consumers.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    SEG_32   = 2'd0,
    SEG_64   = 2'd1,
    SEG_128  = 2'd2,
    SEG_128X = 2'd3
  } seg_code_e;

  // Segment size in bytes for a size code; the spare code maps to the largest size.
  function automatic logic [7:0] seg_bytes(input logic [1:0] code);
    case (code)
      SEG_32:  seg_bytes = 8'd32;
      SEG_64:  seg_bytes = 8'd64;
      default: seg_bytes = 8'd128;
    endcase
  endfunction
endpackage

// File: rtl/coal_first_set.sv
module coal_first_set #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES-1:0]    pend,
  input  logic [AW-1:0]       seg_mask,
  input  logic [AW-1:0]       seg_base,
  output logic [LANES-1:0]    hit
);
  // One comparator per lane: pending lanes whose segment equals the leader's.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = pend[g] && ((lane_addr[g*AW +: AW] & seg_mask) == seg_base);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 32,
  parameter int LW    = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_mask,
  input  logic [1:0]          req_seg,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [7:0]          txn_bytes,
  output logic [LANES-1:0]    txn_lanes,
  output logic                txn_last,
  output logic                done
);
  logic                busy;
  logic [LANES-1:0]    pend;
  logic [LANES*AW-1:0] addr_q;
  logic [1:0]          seg_q;
  logic                done_q;

  logic [AW-1:0]    lane_a [LANES];
  logic [LW-1:0]    lead_idx;
  logic             lead_any;
  logic [AW-1:0]    seg_mask;
  logic [AW-1:0]    lead_base;
  logic [LANES-1:0] hit;
  logic             req_fire;
  logic             txn_fire;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lane_a[g] = addr_q[g*AW +: AW];
  end

  coal_first_set #(.N(LANES), .IW(LW)) u_lead (
    .vec (pend),
    .idx (lead_idx),
    .any (lead_any)
  );

  assign txn_bytes = seg_bytes(seg_q);
  assign seg_mask  = ~(AW'(txn_bytes) - AW'(1));
  assign lead_base = lane_a[lead_idx] & seg_mask;

  coal_seg_match #(.LANES(LANES), .AW(AW)) u_match (
    .lane_addr (addr_q),
    .pend      (pend),
    .seg_mask  (seg_mask),
    .seg_base  (lead_base),
    .hit       (hit)
  );

  assign req_ready = !busy;
  assign txn_valid = busy && lead_any;
  assign txn_base  = lead_base;
  assign txn_lanes = hit;
  assign txn_last  = (pend & ~hit) == '0;
  assign done      = done_q;
  assign req_fire  = req_valid && req_ready;
  assign txn_fire  = txn_valid && txn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      addr_q <= '0;
      seg_q  <= 2'd0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (req_fire) begin
        addr_q <= req_addr;
        seg_q  <= req_seg;
        pend   <= req_mask;
        busy   <= |req_mask;
        done_q <= ~|req_mask;
      end else if (txn_fire) begin
        pend <= pend & ~hit;
        if (txn_last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R2: only the three legal sizes ever leave the block
  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_bytes == 8'd32 || txn_bytes == 8'd64 || txn_bytes == 8'd128));

  // R3: every transaction serves at least one lane
  p_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_lanes != '0);

  // R5: the leader picked by the priority encoder is served by the comparators
  p_leader_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> hit[lead_idx]);

  // R6: a stalled transaction holds its fields
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_lanes)
                                && $stable(txn_bytes) && $stable(txn_last));

  // R7: the completion pulse never overlaps a transaction
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid);

  // R8: an empty request finishes at once
  p_empty_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_mask == '0 |=> done && !txn_valid);

  // R9: with the consumer ready, the next transaction follows back to back
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire && !txn_last |=> txn_valid);
endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int MAX_CYCLES = 150000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [LANES*AW-1:0] req_addr;
  logic [LANES-1:0]    req_mask = '0;
  logic [1:0]          req_seg = 2'd0;
  logic                txn_valid;
  logic                txn_ready = 1'b1;
  logic [AW-1:0]       txn_base;
  logic [7:0]          txn_bytes;
  logic [LANES-1:0]    txn_lanes;
  logic                txn_last;
  logic                done;

  logic [AW-1:0] lane_a [LANES];
  bit stall_mode = 1'b0;

  always_comb
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = lane_a[i];

  warp_coalescer #(.LANES(LANES), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_seg(req_seg),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
    .txn_bytes(txn_bytes), .txn_lanes(txn_lanes), .txn_last(txn_last), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) txn_ready <= stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;

  typedef struct packed {
    logic [AW-1:0]    base;
    logic [7:0]       bytes;
    logic [LANES-1:0] lanes;
  } txn_t;

  txn_t             exp_q[$];
  logic             exp_done = 1'b0;
  logic [LANES-1:0] cur_mask = '0;
  int checks = 0;
  int fails = 0;
  int txn_seen = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int bytes_of(input logic [1:0] s);
    return (s == 2'd0) ? 32 : (s == 2'd1) ? 64 : 128;
  endfunction

  // Behavioural expansion of the current request into its transaction list.
  function automatic void build_list();
    logic [LANES-1:0] left = req_mask;
    logic [AW-1:0]    amask = ~(AW'(bytes_of(req_seg)) - AW'(1));
    while (left != '0) begin
      int   lead = -1;
      txn_t t;
      for (int i = 0; i < LANES; i++) if (left[i] && lead < 0) lead = i;
      t.base  = lane_a[lead] & amask;
      t.bytes = 8'(bytes_of(req_seg));
      t.lanes = '0;
      for (int i = 0; i < LANES; i++)
        if (left[i] && ((lane_a[i] & amask) == t.base)) t.lanes[i] = 1'b1;
      left &= ~t.lanes;
      exp_q.push_back(t);
    end
  endfunction

  // Per-cycle reference: compare at the falling edge, then advance the model.
  always @(negedge clk) begin
    if (rst_n) begin
      logic nd;
      check(done == exp_done, "R7", "done", 64'(done), 64'(exp_done));
      check(req_ready == (exp_q.size() == 0), "R6", "req_ready",
            64'(req_ready), 64'(exp_q.size() == 0));
      check(txn_valid == (exp_q.size() != 0), "R9", "txn_valid",
            64'(txn_valid), 64'(exp_q.size() != 0));
      if (txn_valid && exp_q.size() != 0) begin
        check(txn_base == exp_q[0].base, "R5", "txn_base", 64'(txn_base), 64'(exp_q[0].base));
        check(txn_lanes == exp_q[0].lanes, "R5", "txn_lanes", 64'(txn_lanes), 64'(exp_q[0].lanes));
        check(txn_bytes == exp_q[0].bytes, "R2", "txn_bytes", 64'(txn_bytes), 64'(exp_q[0].bytes));
        check(txn_last == (exp_q.size() == 1), "R7", "txn_last",
              64'(txn_last), 64'(exp_q.size() == 1));
        check((txn_lanes & ~cur_mask) == '0, "R4", "inactive lane served",
              64'(txn_lanes), 64'(txn_lanes & cur_mask));
      end
      nd = 1'b0;
      if (txn_valid && txn_ready && exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        txn_seen++;
        if (exp_q.size() == 0) nd = 1'b1;
      end
      if (req_valid && req_ready) begin
        cur_mask = req_mask;
        build_list();
        if (exp_q.size() == 0) nd = 1'b1;
      end
      exp_done = nd;
    end
  end

  always @(posedge clk) cycles++;

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (cycles > MAX_CYCLES) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  endtask

  // Present one request, wait for completion, compare the transaction count.
  task automatic do_req(input logic [LANES-1:0] m, input logic [1:0] s,
                        input int exp_cnt, input string tag);
    int start;
    req_mask  = m;
    req_seg   = s;
    req_valid = 1'b1;
    while (!req_ready) tick();
    start = txn_seen;
    tick();
    req_valid = 1'b0;
    while (!done) tick();
    if (exp_cnt >= 0)
      check(txn_seen - start == exp_cnt, tag, "transaction count",
            64'(txn_seen - start), 64'(exp_cnt));
    tick();
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) lane_a[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: idle state after reset
    check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    check(txn_valid == 1'b0, "R1", "txn_valid after reset", 64'(txn_valid), 64'd0);
    check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
    tick();

    // R3: unit-stride 4-byte words in one 128-byte segment give one transaction
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h1000 + 32'(i * 4);
    do_req('1, 2'd2, 1, "R3");
    // R2: same addresses with 32-byte and 64-byte segments
    do_req('1, 2'd0, 4, "R2");
    do_req('1, 2'd1, 2, "R2");
    // R2: spare code behaves as 128 bytes; stride 8 spans 256 bytes
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h2040 + 32'(i * 8);
    do_req('1, 2'd3, 3, "R2");
    // R3: widely separated addresses, one transaction per lane
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h8000 + 32'(i * 128);
    do_req('1, 2'd2, 32, "R3");
    // R8: no active lane
    do_req('0, 2'd2, 0, "R8");
    // R4: only even lanes active, each pair shares a segment
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h0 + 32'(i * 64);
    do_req(32'h5555_5555, 2'd2, 16, "R4");
    // R4: a single active lane
    do_req(32'h0001_0000, 2'd0, 1, "R4");
    // R5: interleaved segments, lowest unserved lane leads
    for (int i = 0; i < LANES; i++) lane_a[i] = ((i % 2) != 0 ? 32'h3000 : 32'h0) + 32'(i * 4);
    do_req('1, 2'd2, 2, "R5");

    // R6: stalled consumer, back-pressure on both ports
    stall_mode = 1'b1;
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h9000 + 32'(i * 36);
    do_req('1, 2'd0, 32, "R6");
    // R9 and R5: random scatter and masks, counts checked by the per-cycle model
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < LANES; i++) lane_a[i] = 32'h4000 + 32'($urandom_range(0, 1023));
      stall_mode = (n % 2) == 0;
      do_req(32'($urandom), 2'($urandom_range(0, 3)), -1, "R9");
    end
    stall_mode = 1'b0;
    tick();
    tick();
    finish_run();
  end
endmodule